// File: doc/BRIEF.md
# Return-State Stack Store Unit

This unit carries out one "push return state" operation for a 32-bit processor core. It takes one instruction word, in either a 32-bit wide format or a compact format made of two halfwords. It decides whether the operation is legal for the current and target processor modes. When it is legal, the unit reads the banked stack pointer of the target mode and stores two words to memory: the current return address first, then the saved status word. It can then write an adjusted pointer back into the banked register.

Operations that are not legal end in one of three ways. The unit can flag an undefined instruction, or it can retire the operation as a no-operation, with a configuration input choosing between these two. When the target is the secure monitor mode and the monitor level runs a 64-bit architecture, the unit raises a trap request instead.

The unit accepts one operation at a time. Every accepted operation ends with a one-cycle completion pulse, and the undefined and trap flags show their result in that same cycle.

Top module: `rstate_store`

## Requirements
- R1: Wide format is recognised when bits [31:25]=1111100, bit 22=1 and bit 20=0. Bit 24 is P, bit 23 is U, bit 21 is W and bits [4:0] are the target mode. Compact format (fmt_compact_i=1) is recognised when bits [31:22]=1110100000 (first variant) or 1110100110 (second variant) and bit 20=0. In compact format W is bit 21 and the target mode is bits [4:0]. Any other word gives an undefined result.
- R2: Call the banked pointer read for the target mode the base. The first store address is base when incrementing and base-8 when decrementing, plus 4 when P equals U. The compact first variant acts as P=1, U=0 and the compact second variant acts as P=0, U=1.
- R3: A legal operation issues exactly two word stores. The return address goes to the first address and the status word goes to that address plus 4, in this order. Each request and its address stay stable until mem_gnt_i is seen.
- R4: When W=1, bsp_we_o pulses once, in the completion cycle after the second store has been granted, with base+8 when incrementing or base-8 when decrementing. When W=0 the banked pointer is never written.
- R5: With hyp_level_i=1 the result is always undefined, whatever the other inputs and whatever bad_as_nop_i says.
- R6: Illegal cases are checked in this order: current mode User or System; target Hypervisor; target Monitor when has_mon_level_i=0 or secure_i=0; target not a listed mode. Each gives a no-operation when bad_as_nop_i=1 and undefined otherwise. None of them stores or writes the pointer.
- R7: When the target is Monitor, secure_i=1, has_mon_level_i=1 and mon_is_64_i=1, trap_o is raised and nothing is stored. When mon_is_64_i=0 the stores proceed normally.
- R8: done_o is high for exactly one cycle per accepted operation, one cycle after the last grant, or one cycle after acceptance if there are no stores. undef_o and trap_o are high only together with done_o.
- R9: busy_o is high from the cycle after acceptance until and including the done_o cycle. instr_valid_i is ignored while busy_o is high.
- R10: Mode codes: User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Monitor 10110, Abort 10111, Hypervisor 11010, Undefined 11011, System 11111. Every other code is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word offered |
| instr_i | input | 32 | Instruction word |
| fmt_compact_i | input | 1 | 1 selects compact format |
| cur_mode_i | input | 5 | Current processor mode |
| hyp_level_i | input | 1 | Executing at hypervisor level |
| secure_i | input | 1 | Processor in secure state |
| has_mon_level_i | input | 1 | Monitor level implemented |
| mon_is_64_i | input | 1 | Monitor level runs 64-bit architecture |
| bad_as_nop_i | input | 1 | Illegal cases retire as no-operation |
| ret_addr_i | input | XLEN | Current return address |
| saved_status_i | input | XLEN | Current saved status word |
| bsp_mode_o | output | 5 | Mode whose banked pointer is read or written |
| bsp_rdata_i | input | XLEN | Banked pointer read data (combinational) |
| bsp_we_o | output | 1 | Banked pointer write enable |
| bsp_wdata_o | output | XLEN | Banked pointer write data |
| mem_req_o | output | 1 | Store request |
| mem_addr_o | output | XLEN | Store byte address |
| mem_wdata_o | output | XLEN | Store data |
| mem_gnt_i | input | 1 | Store accepted |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (one cycle) |
| undef_o | output | 1 | Result is undefined instruction |
| trap_o | output | 1 | Trap request to monitor level |

## Verification
The bench builds the unit with its default XLEN of 32, so the ±8 and +4 address offsets are checked against 32-bit bases below, at and above the stacked word pair. The grant delay changes from vector to vector between zero and two cycles. This covers both back-to-back stores and stores held while waiting for a grant. It also lets the bench hold a different instruction at the input during a stalled sequence, which shows that it is ignored.

// File: rtl/rstate_pkg.sv
`timescale 1ns/1ps
package rstate_pkg;
  localparam int unsigned MODE_W = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_MON = 5'b10110,
    MODE_ABT = 5'b10111,
    MODE_HYP = 5'b11010,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef enum logic [1:0] {ACT_STORE, ACT_NOP, ACT_UNDEF, ACT_TRAP} act_e;

  typedef struct packed {
    logic              inc;
    logic              higher;
    logic              wback;
    logic [MODE_W-1:0] tmode;
    act_e              act;
  } op_t;

  function automatic logic mode_known(logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_MON,
      MODE_ABT, MODE_HYP, MODE_UND, MODE_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rstate_decode.sv
`timescale 1ns/1ps
module rstate_decode
  import rstate_pkg::*;
(
  input  logic [31:0]       instr_i,
  input  logic              fmt_compact_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic              hyp_level_i,
  input  logic              secure_i,
  input  logic              has_mon_level_i,
  input  logic              mon_is_64_i,
  input  logic              bad_as_nop_i,
  output op_t               op_o
);
  logic enc_ok, p_bit, u_bit;
  act_e illegal_act;
  logic unused_instr;

  assign unused_instr = ^instr_i[19:5];
  assign illegal_act  = bad_as_nop_i ? ACT_NOP : ACT_UNDEF;

  always_comb begin
    enc_ok = 1'b0;
    p_bit  = 1'b0;
    u_bit  = 1'b0;
    if (!fmt_compact_i) begin
      enc_ok = (instr_i[31:25] == 7'b1111100) && instr_i[22] && !instr_i[20];
      p_bit  = instr_i[24];
      u_bit  = instr_i[23];
    end else if (instr_i[31:22] == 10'b1110100000) begin
      enc_ok = !instr_i[20];
      p_bit  = 1'b1;
      u_bit  = 1'b0;
    end else if (instr_i[31:22] == 10'b1110100110) begin
      enc_ok = !instr_i[20];
      p_bit  = 1'b0;
      u_bit  = 1'b1;
    end
  end

  always_comb begin
    op_o.inc    = u_bit;
    op_o.higher = (p_bit == u_bit);
    op_o.wback  = instr_i[21];
    op_o.tmode  = instr_i[MODE_W-1:0];
    // priority chain: hypervisor level, encoding, then legality order
    if (hyp_level_i || !enc_ok)
      op_o.act = ACT_UNDEF;
    else if (cur_mode_i == MODE_USR || cur_mode_i == MODE_SYS)
      op_o.act = illegal_act;
    else if (op_o.tmode == MODE_HYP)
      op_o.act = illegal_act;
    else if (op_o.tmode == MODE_MON) begin
      if (!has_mon_level_i || !secure_i) op_o.act = illegal_act;
      else if (mon_is_64_i)              op_o.act = ACT_TRAP;
      else                               op_o.act = ACT_STORE;
    end else if (!mode_known(op_o.tmode))
      op_o.act = illegal_act;
    else
      op_o.act = ACT_STORE;
  end
endmodule

// File: rtl/rstate_addr.sv
`timescale 1ns/1ps
module rstate_addr #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] base_i,
  input  logic            inc_i,
  input  logic            higher_i,
  output logic [XLEN-1:0] first_o,
  output logic [XLEN-1:0] second_o,
  output logic [XLEN-1:0] next_sp_o
);
  localparam int unsigned     WORD_B = XLEN / 8;
  localparam logic [XLEN-1:0] WORD   = XLEN'(WORD_B);
  localparam logic [XLEN-1:0] PAIR   = XLEN'(2 * WORD_B);

  logic [XLEN-1:0] low;

  assign low       = inc_i ? base_i : base_i - PAIR;
  assign first_o   = higher_i ? low + WORD : low;
  assign second_o  = first_o + WORD;
  assign next_sp_o = inc_i ? base_i + PAIR : base_i - PAIR;
endmodule

// File: rtl/rstate_store.sv
`timescale 1ns/1ps
module rstate_store
  import rstate_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [31:0]       instr_i,
  input  logic              fmt_compact_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic              hyp_level_i,
  input  logic              secure_i,
  input  logic              has_mon_level_i,
  input  logic              mon_is_64_i,
  input  logic              bad_as_nop_i,
  input  logic [XLEN-1:0]   ret_addr_i,
  input  logic [XLEN-1:0]   saved_status_i,
  output logic [MODE_W-1:0] bsp_mode_o,
  input  logic [XLEN-1:0]   bsp_rdata_i,
  output logic              bsp_we_o,
  output logic [XLEN-1:0]   bsp_wdata_o,
  output logic              mem_req_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic              mem_gnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              undef_o,
  output logic              trap_o
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_FIN} state_e;

  state_e          state_q;
  op_t             op_d, op_q;
  logic [XLEN-1:0] first_d, second_d, nsp_d;
  logic [XLEN-1:0] first_q, second_q, nsp_q, ret_q, stat_q;
  logic            accept;

  rstate_decode u_decode (
    .instr_i         (instr_i),
    .fmt_compact_i   (fmt_compact_i),
    .cur_mode_i      (cur_mode_i),
    .hyp_level_i     (hyp_level_i),
    .secure_i        (secure_i),
    .has_mon_level_i (has_mon_level_i),
    .mon_is_64_i     (mon_is_64_i),
    .bad_as_nop_i    (bad_as_nop_i),
    .op_o            (op_d)
  );

  rstate_addr #(.XLEN(XLEN)) u_addr (
    .base_i    (bsp_rdata_i),
    .inc_i     (op_d.inc),
    .higher_i  (op_d.higher),
    .first_o   (first_d),
    .second_o  (second_d),
    .next_sp_o (nsp_d)
  );

  assign accept = instr_valid_i && (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= '0;
      first_q  <= '0;
      second_q <= '0;
      nsp_q    <= '0;
      ret_q    <= '0;
      stat_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          op_q     <= op_d;
          first_q  <= first_d;
          second_q <= second_d;
          nsp_q    <= nsp_d;
          ret_q    <= ret_addr_i;
          stat_q   <= saved_status_i;
          state_q  <= (op_d.act == ACT_STORE) ? S_LO : S_FIN;
        end
        S_LO:    if (mem_gnt_i) state_q <= S_HI;
        S_HI:    if (mem_gnt_i) state_q <= S_FIN;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // pointer read address follows the offered word while idle
  assign bsp_mode_o  = (state_q == S_IDLE) ? op_d.tmode : op_q.tmode;
  assign mem_req_o   = (state_q == S_LO) || (state_q == S_HI);
  assign mem_addr_o  = (state_q == S_HI) ? second_q : first_q;
  assign mem_wdata_o = (state_q == S_HI) ? stat_q : ret_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign undef_o     = done_o && (op_q.act == ACT_UNDEF);
  assign trap_o      = done_o && (op_q.act == ACT_TRAP);
  assign bsp_we_o    = done_o && (op_q.act == ACT_STORE) && op_q.wback;
  assign bsp_wdata_o = nsp_q;
endmodule

// File: rtl/rstate_store_chk.sv
`timescale 1ns/1ps
module rstate_store_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_gnt_i,
  input logic            bsp_we_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            undef_o,
  input logic            trap_o
);
  localparam logic [XLEN-1:0] WORD = XLEN'(XLEN / 8);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + WORD));

  p_req_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  p_wb_after_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsp_we_o |-> $past(mem_req_o && mem_gnt_i) && done_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_flags_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || trap_o) |-> done_o && $onehot0({undef_o, trap_o}));

  p_fault_no_wb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || trap_o) |-> !bsp_we_o);

  p_busy_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
endmodule

bind rstate_store rstate_store_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_gnt_i  (mem_gnt_i),
  .bsp_we_o   (bsp_we_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .undef_o    (undef_o),
  .trap_o     (trap_o)
);

// File: tb/rstate_store_tb.sv
`timescale 1ns/1ps
module rstate_store_tb;
  localparam int unsigned XLEN = 32;
  localparam int NV = 19;

  // act: 0 store, 1 no-op, 2 undefined, 3 trap
  typedef struct packed {
    logic        cmp;
    logic        p;
    logic        u;
    logic        w;
    logic        bad;
    logic [4:0]  tmode;
    logic [4:0]  cmode;
    logic        hyp;
    logic        sec;
    logic        hmon;
    logic        m64;
    logic        nop;
    logic [31:0] base;
    logic [1:0]  act;
    logic [31:0] a0;
    logic [31:0] sp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b0,5'h13,5'h12,1'b0,1'b1,1'b1,1'b0,1'b0,32'h1000,2'd0,32'h0FFC,32'h0FF8,4'd2},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,5'h11,5'h12,1'b0,1'b1,1'b1,1'b0,1'b0,32'h2000,2'd0,32'h1FF8,32'h2000,4'd4},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h17,5'h12,1'b0,1'b1,1'b1,1'b0,1'b0,32'h3000,2'd0,32'h3000,32'h3008,4'd2},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,5'h1B,5'h13,1'b0,1'b1,1'b1,1'b0,1'b0,32'h4000,2'd0,32'h4004,32'h4008,4'd2},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,5'h13,5'h11,1'b0,1'b1,1'b1,1'b0,1'b0,32'h5000,2'd0,32'h4FF8,32'h4FF8,4'd1},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,5'h12,5'h17,1'b0,1'b0,1'b1,1'b0,1'b0,32'h6000,2'd0,32'h6000,32'h6008,4'd1},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h13,5'h10,1'b0,1'b1,1'b1,1'b0,1'b1,32'h1000,2'd1,32'h0,32'h1000,4'd6},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h13,5'h1F,1'b0,1'b1,1'b1,1'b0,1'b0,32'h1000,2'd2,32'h0,32'h1000,4'd6},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h1A,5'h13,1'b0,1'b1,1'b1,1'b0,1'b1,32'h1000,2'd1,32'h0,32'h1000,4'd6},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h16,5'h13,1'b0,1'b0,1'b1,1'b0,1'b0,32'h1000,2'd2,32'h0,32'h1000,4'd6},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h16,5'h13,1'b0,1'b1,1'b0,1'b0,1'b1,32'h1000,2'd1,32'h0,32'h1000,4'd6},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h14,5'h13,1'b0,1'b1,1'b1,1'b0,1'b0,32'h1000,2'd2,32'h0,32'h1000,4'd10},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h16,5'h13,1'b0,1'b1,1'b1,1'b1,1'b0,32'h1000,2'd3,32'h0,32'h1000,4'd7},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,5'h16,5'h13,1'b0,1'b1,1'b1,1'b0,1'b0,32'h7000,2'd0,32'h7004,32'h7008,4'd7},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h13,5'h12,1'b1,1'b1,1'b1,1'b0,1'b1,32'h1000,2'd2,32'h0,32'h1000,4'd5},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h13,5'h10,1'b1,1'b1,1'b1,1'b0,1'b1,32'h1000,2'd2,32'h0,32'h1000,4'd5},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,5'h16,5'h10,1'b0,1'b1,1'b1,1'b1,1'b1,32'h1000,2'd1,32'h0,32'h1000,4'd6},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,5'h13,5'h12,1'b0,1'b1,1'b1,1'b0,1'b1,32'h1000,2'd2,32'h0,32'h1000,4'd1},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,5'h13,5'h12,1'b0,1'b1,1'b1,1'b0,1'b1,32'h1000,2'd2,32'h0,32'h1000,4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic fmt_compact = 1'b0;
  logic [4:0] cur_mode = 5'h13;
  logic hyp_level = 1'b0, secure = 1'b1, has_mon = 1'b1, mon64 = 1'b0, bad_nop = 1'b0;
  logic [XLEN-1:0] ret_addr = '0, saved_status = '0;
  logic [4:0] bsp_mode;
  logic [XLEN-1:0] bsp_rdata, bsp_wdata, mem_addr, mem_wdata;
  logic bsp_we, mem_req, busy, done, undef, trap;
  logic mem_gnt = 1'b0;
  logic [XLEN-1:0] bank [32];

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  assign bsp_rdata = bank[bsp_mode];

  rstate_store #(.XLEN(XLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .fmt_compact_i(fmt_compact), .cur_mode_i(cur_mode), .hyp_level_i(hyp_level),
    .secure_i(secure), .has_mon_level_i(has_mon), .mon_is_64_i(mon64),
    .bad_as_nop_i(bad_nop), .ret_addr_i(ret_addr), .saved_status_i(saved_status),
    .bsp_mode_o(bsp_mode), .bsp_rdata_i(bsp_rdata), .bsp_we_o(bsp_we),
    .bsp_wdata_o(bsp_wdata), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .busy_o(busy), .done_o(done),
    .undef_o(undef), .trap_o(trap)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(input vec_t v, input int idx, input int dly, input bit junk);
    logic [31:0] al [2];
    logic [31:0] dl [2];
    int nst = 0;
    int nwe = 0;
    int waitc = 0;
    bit got_done = 1'b0;
    logic g_undef = 1'b0, g_trap = 1'b0;
    logic [31:0] ra = 32'hA000_0000 + idx;
    logic [31:0] st = 32'h5000_0010 + idx;
    logic [31:0] exp_sp;
    string t = tag(v.req);
    al[0] = '0; al[1] = '0; dl[0] = '0; dl[1] = '0;
    @(negedge clk);
    bank[v.tmode] = v.base;
    fmt_compact = v.cmp;
    if (!v.cmp)
      instr = {7'b1111100, v.p, v.u, ~v.bad, v.w, 1'b0, 15'h0, v.tmode};
    else
      instr = {(v.p ? 10'b1110100110 : 10'b1110100000), v.w, v.bad, 4'b1101,
               11'b11000000000, v.tmode};
    cur_mode = v.cmode; hyp_level = v.hyp; secure = v.sec; has_mon = v.hmon;
    mon64 = v.m64; bad_nop = v.nop; ret_addr = ra; saved_status = st;
    instr_valid = 1'b1;
    @(negedge clk);
    if (junk) instr = 32'hFFFF_FFFF;
    else instr_valid = 1'b0;
    for (int c = 0; c < 60; c++) begin
      mem_gnt = 1'b0;
      if (done) begin
        got_done = 1'b1;
        g_undef = undef; g_trap = trap;
        if (bsp_we) begin
          nwe++;
          bank[bsp_mode] = bsp_wdata;
        end
        instr_valid = 1'b0;
        break;
      end
      if (mem_req) begin
        if (waitc >= dly) begin
          if (nst < 2) begin al[nst] = mem_addr; dl[nst] = mem_wdata; end
          nst++;
          mem_gnt = 1'b1;
          waitc = 0;
        end else waitc++;
      end
      @(negedge clk);
    end
    chk(got_done, "R8", "done seen", {31'b0, got_done}, 32'd1);
    chk({g_undef, g_trap} == {v.act == 2'd2, v.act == 2'd3}, t, "outcome flags",
        {30'b0, g_undef, g_trap}, {30'b0, v.act == 2'd2, v.act == 2'd3});
    chk(nst == ((v.act == 2'd0) ? 2 : 0), "R3", "store count", nst, (v.act == 2'd0) ? 2 : 0);
    if (v.act == 2'd0) begin
      chk(al[0] == v.a0, "R2", "first address", al[0], v.a0);
      chk(dl[0] == ra, "R3", "first data", dl[0], ra);
      chk(al[1] == v.a0 + 4, "R3", "second address", al[1], v.a0 + 4);
      chk(dl[1] == st, "R3", "second data", dl[1], st);
    end
    exp_sp = (v.act == 2'd0 && v.w) ? v.sp : v.base;
    chk(bank[v.tmode] == exp_sp, "R4", "banked pointer", bank[v.tmode], exp_sp);
    chk(nwe == ((v.act == 2'd0 && v.w) ? 1 : 0), "R4", "pointer writes", nwe,
        (v.act == 2'd0 && v.w) ? 1 : 0);
    @(negedge clk);
    chk(!done && !busy, "R9", "idle after done", {30'b0, done, busy}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) bank[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !bsp_we && !undef && !trap, "R8", "reset state",
        {26'b0, busy, done, mem_req, bsp_we, undef, trap}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_op(VECS[i], i, i % 3, 1'b0);
    // R9: a different word held valid during a stalled sequence is ignored
    run_op(VECS[3], 40, 3, 1'b1);
    // R9/R10: back-to-back operations on an unlisted mode then a listed one
    run_op(VECS[11], 41, 0, 1'b0);
    run_op(VECS[2], 42, 0, 1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule